// File: doc/BRIEF.md
# Serial Peripheral Master with Segment-Timed Framing

This block drives a four-wire serial peripheral bus as the master. Words written into a four-entry transmit queue are shifted out on `mosi` while the reply on `miso` is gathered into a four-entry receive queue. The chip-select line is owned by the hardware. It drops when a word leaves the transmit queue and rises again after the stop segment. In hold mode it stays low across words as long as another word is already waiting.

Every segment of a frame has its own length, counted in clock cycles. The segments are the select-to-first-edge lead, the two clock half-phases, the tail after the last edge and the idle gap between frames. Clock polarity, clock phase and frame size are configurable: 8 or 16 bits. The byte order and bit order on the wire can each be reversed. A discard control lets the block transmit without filling the receive queue. Configuration inputs are expected to be static while a frame is in flight.

Top module: `spi_phase_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` equals `clk_pol`, both queue counts are 0 and all three sticky flags are 0.
- R2: Each length input holds the desired cycle count minus one. With value L, the lead (select low, clock idle before the first edge) lasts L+1 cycles, and so does each clock half-phase. Counted from the end of the last bit's second half-phase, the tail lasts `stop_len`+1 cycles. Between two frames that are not merged, `cs_n` stays high for `gap_len`+2 cycles when the next word is already queued.
- R3: `cs_n` falls only when a word is taken from the transmit queue, and it rises after the tail without any host action. With `hold_select`=1 and the next word already queued at the end of a word, `cs_n` stays low and the next word follows directly. Otherwise `cs_n` rises after each word.
- R4: `frame_16`=0 selects 8-bit words and `frame_16`=1 selects 16-bit words. Each word produces exactly that many clock pulses. In 8-bit mode only `tx_wdata[7:0]` is sent and received words have bits 15:8 at 0.
- R5: Wire order: the word is split into byte 0 (bits 7:0) and byte 1 (bits 15:8). With `byte_swap`=0, byte 0 goes first. With `byte_swap`=1 in 16-bit mode, byte 1 goes first. Within each byte, `lsb_first`=0 sends bit 7 first and `lsb_first`=1 sends bit 0 first.
- R6: When `cs_n` is high, and during the lead and the tail, `sclk` rests at `clk_pol`. With `clk_pha`=0, `miso` is captured on the first edge of each bit and `mosi` is already valid during the lead. With `clk_pha`=1, `mosi` changes on the first edge and is captured on the second edge.
- R7: Each received bit is stored at the word position that the transmitted bit of the same slot came from, so looping `mosi` back to `miso` returns the sent word. The word enters the receive queue at the end of its last bit. `rx_rdata` shows the oldest entry whenever `rx_count` is nonzero, and `rx_pop` removes it.
- R8: With `rx_discard`=1, completed words are not written to the receive queue. `rx_count` stays unchanged, but the wire activity is the same.
- R9: Each queue holds 4 entries and reports its count. A push into a full queue is dropped and sets its sticky overflow flag. A pop from an empty receive queue is dropped and sets `rx_underflow`. A clear pulse empties the queue and resets its flags.
- R10: A frame starts only while `master_en`=1 and the transmit queue is non-empty. A queued word stays in the queue while `master_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Allows new frames to start |
| clk_pol | input | 1 | Idle level of `sclk` |
| clk_pha | input | 1 | 0: capture on first edge, 1: capture on second edge |
| frame_16 | input | 1 | 0: 8-bit words, 1: 16-bit words |
| byte_swap | input | 1 | 1: upper byte first in 16-bit mode |
| lsb_first | input | 1 | 1: each byte sent least significant bit first |
| hold_select | input | 1 | Keep select low across back-to-back words |
| rx_discard | input | 1 | Drop received words instead of queueing them |
| start_len | input | SEG_W | Lead length minus one |
| ph0_len | input | SEG_W | First half-phase length minus one |
| ph1_len | input | SEG_W | Second half-phase length minus one |
| stop_len | input | SEG_W | Tail length minus one |
| gap_len | input | SEG_W | Inter-frame idle length minus one |
| tx_push | input | 1 | Write `tx_wdata` into the transmit queue |
| tx_wdata | input | 16 | Word to transmit |
| tx_clear | input | 1 | Empty the transmit queue and reset its flag |
| tx_count | output | CNT_W | Transmit queue occupancy |
| tx_overflow | output | 1 | Sticky: push into a full transmit queue |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_rdata | output | 16 | Oldest received word |
| rx_clear | input | 1 | Empty the receive queue and reset its flags |
| rx_count | output | CNT_W | Receive queue occupancy |
| rx_overflow | output | 1 | Sticky: completed word dropped by a full receive queue |
| rx_underflow | output | 1 | Sticky: pop from an empty receive queue |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench plays the peripheral. It captures `mosi` on the capture edge that the mode implies, rebuilds the wire bit sequence and compares it with an order computed from the byte and bit rules. A design that swapped the wrong byte, or reversed bits across the whole word instead of within bytes, gives a wrong sequence. One that gave a phase mode an extra or missing pulse gives the wrong bit count. With `miso` looped back, every received word must equal the sent word, which exposes a receive path that places bits differently from the transmit path.

Segment lengths are measured in one mode with five distinct values, so an off-by-one in the minus-one encoding or a swapped length shows up as a wrong run length. Select falls are counted with hold mode on and off: hold mode must give a single select-low window for three words, and normal mode three. Full, empty, discard and disabled cases are checked at the count and flag outputs, where a dropped push that corrupted the queue, or a discarded word that still landed in it, would be visible.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

  localparam int DATA_W = 16;
  localparam int BIT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HALF_A,
    ST_HALF_B,
    ST_TAIL,
    ST_GAP
  } spi_pm_state_e;

  // Maps the k-th bit on the wire to its position in the data word.
  function automatic logic [BIT_W-1:0] wire_slot(
    input logic [BIT_W-1:0] k,
    input logic             wide,
    input logic             swap,
    input logic             lsb
  );
    logic       byte_sel;
    logic [2:0] bit_sel;
    byte_sel = (wide && swap) ? ~k[3] : k[3];
    bit_sel  = lsb ? k[2:0] : ~k[2:0];
    return {byte_sel, bit_sel};
  endfunction

endpackage

// File: rtl/spi_pm_fifo.sv
module spi_pm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             overflow,
  output logic             underflow
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else begin
      if (do_push) wr_d = step(wr_q);
      if (do_pop)  rd_d = step(rd_q);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
      if (push && full)  ovf_d = 1'b1;
      if (pop && empty)  unf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // Storage carries no reset; entries are only read once written.
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end

  assign rdata     = mem_q[rd_q];
  assign count     = cnt_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

endmodule

// File: rtl/spi_pm_engine.sv
module spi_pm_engine
  import spi_pm_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              clk_pol,
  input  logic              clk_pha,
  input  logic              frame_16,
  input  logic              byte_swap,
  input  logic              lsb_first,
  input  logic              hold_select,
  input  logic              rx_discard,
  input  logic [SEG_W-1:0]  start_len,
  input  logic [SEG_W-1:0]  ph0_len,
  input  logic [SEG_W-1:0]  ph1_len,
  input  logic [SEG_W-1:0]  stop_len,
  input  logic [SEG_W-1:0]  gap_len,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_head,
  output logic              tx_take,
  output logic              rx_put,
  output logic [DATA_W-1:0] rx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);

  spi_pm_state_e     state_q, state_d;
  logic [SEG_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] txw_q;
  logic [DATA_W-1:0] rxw_q, rxw_d;
  logic              rxw_en;
  logic [SEG_W-1:0]  seg_len;
  logic              seg_done;
  logic [BIT_W-1:0]  last_bit;
  logic [BIT_W-1:0]  slot;
  logic              may_start;

  assign last_bit  = frame_16 ? BIT_W'(15) : BIT_W'(7);
  assign slot      = wire_slot(bit_q, frame_16, byte_swap, lsb_first);
  assign may_start = master_en && tx_avail;

  always_comb begin
    unique case (state_q)
      ST_LEAD:   seg_len = start_len;
      ST_HALF_A: seg_len = ph0_len;
      ST_HALF_B: seg_len = ph1_len;
      ST_TAIL:   seg_len = stop_len;
      ST_GAP:    seg_len = gap_len;
      default:   seg_len = '0;
    endcase
  end

  assign seg_done = (cnt_q == seg_len);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    rxw_d   = rxw_q;
    rxw_en  = 1'b0;
    tx_take = 1'b0;
    rx_put  = 1'b0;
    cnt_d   = (state_q == ST_IDLE || seg_done) ? '0 : cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (may_start) begin
          tx_take = 1'b1;
          bit_d   = '0;
          rxw_d   = '0;
          rxw_en  = 1'b1;
          state_d = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (seg_done) state_d = ST_HALF_A;
      end
      ST_HALF_A: begin
        if (seg_done) begin
          rxw_d[slot] = miso;
          rxw_en      = 1'b1;
          state_d     = ST_HALF_B;
        end
      end
      ST_HALF_B: begin
        if (seg_done) begin
          if (bit_q == last_bit) begin
            rx_put = !rx_discard;
            if (hold_select && may_start) begin
              tx_take = 1'b1;
              bit_d   = '0;
              rxw_d   = '0;
              rxw_en  = 1'b1;
              state_d = ST_HALF_A;
            end else begin
              state_d = ST_TAIL;
            end
          end else begin
            bit_d   = bit_q + 1'b1;
            state_d = ST_HALF_A;
          end
        end
      end
      ST_TAIL: begin
        if (seg_done) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (seg_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      txw_q   <= '0;
      rxw_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      if (tx_take) txw_q <= tx_head;
      if (rxw_en)  rxw_q <= rxw_d;
    end
  end

  assign cs_n    = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign sclk    = clk_pol ^ (clk_pha ? (state_q == ST_HALF_A) : (state_q == ST_HALF_B));
  assign mosi    = (state_q == ST_LEAD || state_q == ST_HALF_A || state_q == ST_HALF_B)
                   ? txw_q[slot] : 1'b0;
  assign rx_word = rxw_q;

endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
  import spi_pm_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int SEG_W      = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              clk_pol,
  input  logic              clk_pha,
  input  logic              frame_16,
  input  logic              byte_swap,
  input  logic              lsb_first,
  input  logic              hold_select,
  input  logic              rx_discard,
  input  logic [SEG_W-1:0]  start_len,
  input  logic [SEG_W-1:0]  ph0_len,
  input  logic [SEG_W-1:0]  ph1_len,
  input  logic [SEG_W-1:0]  stop_len,
  input  logic [SEG_W-1:0]  gap_len,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_clear,
  output logic [CNT_W-1:0]  tx_count,
  output logic              tx_overflow,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              rx_clear,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_overflow,
  output logic              rx_underflow,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  logic              tx_take;
  logic [DATA_W-1:0] tx_head;
  logic              rx_put;
  logic [DATA_W-1:0] rx_word;
  logic              tx_underflow_unused;

  spi_pm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (tx_clear),
    .push      (tx_push),
    .wdata     (tx_wdata),
    .pop       (tx_take),
    .rdata     (tx_head),
    .count     (tx_count),
    .overflow  (tx_overflow),
    .underflow (tx_underflow_unused)
  );

  spi_pm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rx_clear),
    .push      (rx_put),
    .wdata     (rx_word),
    .pop       (rx_pop),
    .rdata     (rx_rdata),
    .count     (rx_count),
    .overflow  (rx_overflow),
    .underflow (rx_underflow)
  );

  spi_pm_engine #(.SEG_W(SEG_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .clk_pol     (clk_pol),
    .clk_pha     (clk_pha),
    .frame_16    (frame_16),
    .byte_swap   (byte_swap),
    .lsb_first   (lsb_first),
    .hold_select (hold_select),
    .rx_discard  (rx_discard),
    .start_len   (start_len),
    .ph0_len     (ph0_len),
    .ph1_len     (ph1_len),
    .stop_len    (stop_len),
    .gap_len     (gap_len),
    .tx_avail    (tx_count != '0 && !tx_clear),
    .tx_head     (tx_head),
    .tx_take     (tx_take),
    .rx_put      (rx_put),
    .rx_word     (rx_word),
    .miso        (miso),
    .sclk        (sclk),
    .mosi        (mosi),
    .cs_n        (cs_n)
  );

endmodule

// File: rtl/spi_phase_master_chk.sv
module spi_phase_master_chk #(
  parameter int CNT_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             clk_pol,
  input logic             master_en,
  input logic             rx_discard,
  input logic             tx_clear,
  input logic             tx_overflow,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count
);

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == clk_pol));

  assert_start_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(master_en));

  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_overflow && !tx_clear) |=> tx_overflow);

  assert_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

  assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count > $past(rx_count)) |-> !$past(rx_discard));

endmodule

bind spi_phase_master spi_phase_master_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .clk_pol     (clk_pol),
  .master_en   (master_en),
  .rx_discard  (rx_discard),
  .tx_clear    (tx_clear),
  .tx_overflow (tx_overflow),
  .tx_count    (tx_count),
  .rx_count    (rx_count)
);

// File: tb/spi_phase_master_bench.sv
module spi_phase_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int SEG_W      = 8;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic clk, rst_n;
  logic master_en, clk_pol, clk_pha, frame_16, byte_swap, lsb_first, hold_select, rx_discard;
  logic [SEG_W-1:0] start_len, ph0_len, ph1_len, stop_len, gap_len;
  logic tx_push, tx_clear, rx_clear, mon_pop, man_pop, rx_pop;
  logic [15:0] tx_wdata, rx_rdata;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic tx_overflow, rx_overflow, rx_underflow;
  logic sclk, mosi, miso, cs_n;

  int checks = 0;
  int errors = 0;
  int cs_falls = 0;
  bit auto_pop = 1'b1;
  logic [15:0] exp_wire[$];
  logic [15:0] exp_rx[$];

  assign rx_pop = mon_pop | man_pop;
  assign miso   = mosi;

  spi_phase_master #(.FIFO_DEPTH(DEPTH), .SEG_W(SEG_W)) u_spi_phase_master (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .clk_pol(clk_pol), .clk_pha(clk_pha),
    .frame_16(frame_16), .byte_swap(byte_swap), .lsb_first(lsb_first),
    .hold_select(hold_select), .rx_discard(rx_discard),
    .start_len(start_len), .ph0_len(ph0_len), .ph1_len(ph1_len),
    .stop_len(stop_len), .gap_len(gap_len),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_clear(tx_clear),
    .tx_count(tx_count), .tx_overflow(tx_overflow),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_clear(rx_clear),
    .rx_count(rx_count), .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // Expected wire sequence: entry k is the k-th bit on the wire.
  function automatic logic [15:0] wire_seq(input logic [15:0] d, input logic wide,
                                           input logic swap, input logic lsb);
    logic [15:0] w;
    int n;
    w = '0;
    n = wide ? 16 : 8;
    for (int k = 0; k < n; k++) begin
      int src_byte, src_bit;
      src_byte = (wide && swap) ? 1 - (k / 8) : (k / 8);
      src_bit  = lsb ? (k % 8) : 7 - (k % 8);
      w[k] = d[src_byte * 8 + src_bit];
    end
    return w;
  endfunction

  task automatic raw_push(input logic [15:0] d);
    @(negedge clk);
    tx_wdata = d;
    tx_push  = 1'b1;
    @(negedge clk);
    tx_push  = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input bit expect_rx);
    exp_wire.push_back(wire_seq(d, frame_16, byte_swap, lsb_first));
    if (expect_rx && !rx_discard) exp_rx.push_back(frame_16 ? d : {8'h00, d[7:0]});
    raw_push(d);
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 8) begin
      @(negedge clk);
      if (cs_n && tx_count == '0 && exp_wire.size() == 0 && (exp_rx.size() == 0 || !auto_pop))
        quiet++;
      else
        quiet = 0;
    end
  endtask

  // Wire monitor: peripheral side capture on the mode's capture edge.
  initial begin
    logic        prev;
    logic [15:0] acc;
    int          nb;
    prev = 1'b0;
    acc  = '0;
    nb   = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev = clk_pol;
        nb   = 0;
      end else begin
        if (!cs_n && sclk != prev && ((clk_pha == 1'b0) ? (sclk != clk_pol) : (sclk == clk_pol))) begin
          acc[nb] = mosi;
          nb++;
          if (nb == (frame_16 ? 16 : 8)) begin
            if (exp_wire.size() == 0) begin
              check(1'b0, "R4 unexpected word on wire", int'(acc), 0);
            end else begin
              logic [15:0] e;
              e = exp_wire.pop_front();
              check(acc == e, "R5 wire order / R4 bit count", int'(acc), int'(e));
            end
            acc = '0;
            nb  = 0;
          end
        end
        prev = sclk;
      end
    end
  end

  // Select edge counter.
  initial begin
    logic prev_cs;
    prev_cs = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev_cs && !cs_n) cs_falls++;
      prev_cs = cs_n;
    end
  end

  // Receive scoreboard monitor.
  initial begin
    mon_pop = 1'b0;
    forever begin
      @(negedge clk);
      mon_pop = 1'b0;
      if (rst_n && auto_pop && rx_count != '0) begin
        if (exp_rx.size() == 0) begin
          check(1'b0, "R7 unexpected received word", int'(rx_rdata), 0);
        end else begin
          logic [15:0] e;
          e = exp_rx.pop_front();
          check(rx_rdata == e, "R7 received word", int'(rx_rdata), int'(e));
        end
        mon_pop = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, h, l, t, g, base;
    rst_n = 1'b0;
    master_en = 1'b0; clk_pol = 1'b0; clk_pha = 1'b0; frame_16 = 1'b0;
    byte_swap = 1'b0; lsb_first = 1'b0; hold_select = 1'b0; rx_discard = 1'b0;
    start_len = 8'd1; ph0_len = 8'd1; ph1_len = 8'd1; stop_len = 8'd1; gap_len = 8'd1;
    tx_push = 1'b0; tx_wdata = '0; tx_clear = 1'b0; rx_clear = 1'b0; man_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    check(sclk == clk_pol, "R1 sclk", int'(sclk), int'(clk_pol));
    check(tx_count == 0 && rx_count == 0, "R1 counts", int'({tx_count, rx_count}), 0);
    check({tx_overflow, rx_overflow, rx_underflow} == 3'b000, "R1 flags",
          int'({tx_overflow, rx_overflow, rx_underflow}), 0);

    // R4 R5 R7: 8-bit mode 0
    master_en = 1'b1;
    send(16'h00A5, 1); send(16'h003C, 1); send(16'h0001, 1); send(16'hFF80, 1);
    wait_idle();

    // R5: 16-bit order combinations
    frame_16 = 1'b1;
    for (int c = 0; c < 4; c++) begin
      byte_swap = c[1];
      lsb_first = c[0];
      send(16'h12C5, 1);
      wait_idle();
    end
    byte_swap = 1'b0; lsb_first = 1'b0;

    // R6: other clock modes
    for (int m = 1; m < 4; m++) begin
      clk_pol = m[1];
      clk_pha = m[0];
      send(16'hB38E, 1);
      wait_idle();
      check(sclk == clk_pol, "R6 idle level after frame", int'(sclk), int'(clk_pol));
    end

    // R2: segment lengths, mode 1, 8-bit
    clk_pol = 1'b0; clk_pha = 1'b1; frame_16 = 1'b0;
    start_len = 8'd2; ph0_len = 8'd1; ph1_len = 8'd3; stop_len = 8'd4; gap_len = 8'd5;
    master_en = 1'b0;
    send(16'h0069, 1); send(16'h0096, 1);
    @(negedge clk);
    master_en = 1'b1;
    @(negedge clk);
    a = 0; while (!cs_n && sclk == clk_pol) begin a++; @(negedge clk); end
    check(a == 3, "R2 lead length", a, 3);
    h = 0; while (sclk != clk_pol) begin h++; @(negedge clk); end
    check(h == 2, "R2 first half-phase", h, 2);
    l = 0; while (!cs_n && sclk == clk_pol) begin l++; @(negedge clk); end
    check(l == 4, "R2 second half-phase", l, 4);
    t = 0;
    while (!cs_n) begin
      if (sclk != clk_pol) t = 0; else t++;
      @(negedge clk);
    end
    check(t == 9, "R2 tail after last edge", t, 9);
    g = 0; while (cs_n) begin g++; @(negedge clk); end
    check(g == 7, "R2 gap between frames", g, 7);
    wait_idle();
    start_len = 8'd1; ph0_len = 8'd1; ph1_len = 8'd1; stop_len = 8'd1; gap_len = 8'd1;
    clk_pha = 1'b0;

    // R3: hold mode merges queued words
    master_en = 1'b0; hold_select = 1'b1;
    send(16'h0011, 1); send(16'h0022, 1); send(16'h0033, 1);
    base = cs_falls;
    master_en = 1'b1;
    wait_idle();
    check(cs_falls - base == 1, "R3 hold mode select windows", cs_falls - base, 1);
    master_en = 1'b0; hold_select = 1'b0;
    send(16'h0044, 1); send(16'h0055, 1); send(16'h0066, 1);
    base = cs_falls;
    master_en = 1'b1;
    wait_idle();
    check(cs_falls - base == 3, "R3 normal mode select windows", cs_falls - base, 3);

    // R8: discard
    rx_discard = 1'b1;
    send(16'h005A, 1);
    wait_idle();
    check(rx_count == 0, "R8 discarded word not queued", int'(rx_count), 0);
    rx_discard = 1'b0;

    // R10: disabled master holds its queue
    master_en = 1'b0;
    base = cs_falls;
    send(16'h00C3, 1);
    repeat (40) @(negedge clk);
    check(cs_falls == base && cs_n, "R10 no frame while disabled", cs_falls - base, 0);
    check(tx_count == 1, "R10 word kept queued", int'(tx_count), 1);
    master_en = 1'b1;
    wait_idle();

    // R9: transmit overflow and clear
    master_en = 1'b0;
    for (int i = 0; i < 5; i++) raw_push(16'h0100 + 16'(i));
    check(tx_count == 4, "R9 tx depth", int'(tx_count), 4);
    check(tx_overflow == 1'b1, "R9 tx overflow", int'(tx_overflow), 1);
    @(negedge clk); tx_clear = 1'b1; @(negedge clk); tx_clear = 1'b0;
    check(tx_count == 0 && !tx_overflow, "R9 tx clear", int'({tx_overflow, tx_count}), 0);

    // R9: receive underflow
    auto_pop = 1'b0;
    @(negedge clk); man_pop = 1'b1; @(negedge clk); man_pop = 1'b0;
    check(rx_underflow == 1'b1 && rx_count == 0, "R9 rx underflow", int'(rx_underflow), 1);

    // R9: receive overflow
    master_en = 1'b1;
    for (int i = 0; i < 5; i++) send(16'h0070 + 16'(i), i < 4);
    wait_idle();
    check(rx_count == 4, "R9 rx depth", int'(rx_count), 4);
    check(rx_overflow == 1'b1, "R9 rx overflow", int'(rx_overflow), 1);
    auto_pop = 1'b1;
    wait_idle();
    check(rx_count == 0, "R7 rx drained", int'(rx_count), 0);
    @(negedge clk); rx_clear = 1'b1; @(negedge clk); rx_clear = 1'b0;
    check(!rx_overflow && !rx_underflow, "R9 rx clear", int'({rx_overflow, rx_underflow}), 0);

    check(exp_wire.size() == 0 && exp_rx.size() == 0, "R7 scoreboard empty",
          exp_wire.size() + exp_rx.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule